// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause 22 MDIO management master for talking to external PHY devices. Software drives it through two 32-bit registers on a plain register port. The control register holds the MDC divider and a preamble enable, and it reports a busy flag. The data register takes a command word whose fields are the serial frame itself. When the block is idle, a write to the data register starts one frame on MDC and MDIO.

The command word is shifted out from bit 31 down to bit 0. An optional run of 32 ones goes first. For a read opcode, the master stops driving MDIO after the register address field. It then samples the 16 bits that the PHY returns into the low half of the same register. Software polls the busy flag and then reads the result. The divider can be rewritten at any time, for example to restore settings after a power-state change.

Top module: `mdio_master`

## Requirements
- R1: After reset, the control register reads 0x0000009A: divider 0x1A, preamble enabled (bit 7) and busy (bit 8) clear. The data register reads 0, MDC is low and MDIO is not driven.
- R2: A control write (reg_sel = 0) stores the divider from bits 6:0 and the preamble enable from bit 7. Bit 8 always shows busy, and writes to it have no effect.
- R3: MDC runs only while busy is high and stays low otherwise. Its period is 2×(divider+1) clock cycles, and each frame begins with a low half-period.
- R4: A data-register write (reg_sel = 1) while idle latches the command word and sets busy in the next cycle. Busy stays high for (N+1) MDC periods, where N is the number of frame bits, and then clears.
- R5: When bit 7 is set at launch, 32 driven ones come before bit 31 of the command (N = 64). When bit 7 is clear, the frame starts directly with bit 31 (N = 32).
- R6: Command bits go out MSB first, one per MDC period. MDIO changes only after a falling MDC edge and is stable at the rising edge. For any opcode other than 10 (bits 29:28), all 32 bits are driven.
- R7: For opcode 10 (read), bits 31:18 are driven and MDIO is released for the 18 turnaround and data bit times (bits 17:0).
- R8: On a read, the PHY value is sampled at each rising MDC edge into data-register bits 15:0, MSB first. Bits 31:16 keep their written value, and the result can be read once busy clears.
- R9: A data-register write while busy is ignored. The frame on the pins and the stored command are unchanged.
- R10: After the last frame bit, MDIO is released and one full MDC period passes with MDC ending low before busy clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (tri-state control) |
| mdio_i | input | 1 | MDIO input value from the pin |

## Verification
Some properties are checked on every cycle. MDC and the output enable are quiet whenever the block is idle, and MDC rises only while busy. A driven MDIO value changes only on a falling MDC edge. The output is released before busy drops, an idle launch always raises busy, and the stored command's upper half stays fixed while a frame is in flight. Other behaviour needs the bench scenarios. These include the exact bit sequence against an expected queue (preamble on and off, write and read opcodes), the measured MDC period and busy duration for two divider values, the captured read data, and the register contents after a write that arrives mid-frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int CMD_W     = 32;
    localparam int PRE_LEN   = 32;
    localparam int IDX_W     = $clog2(CMD_W + PRE_LEN);
    localparam int DATA_W    = 16;
    localparam int REL_MSB   = 17;   // highest bit released on a read
    localparam int PRE_BIT   = 7;
    localparam int BUSY_BIT  = 8;

    localparam logic [1:0] OP_READ = 2'b10;

    typedef struct packed {
        logic [1:0]        st;
        logic [1:0]        op;
        logic [4:0]        phy;
        logic [4:0]        regad;
        logic [1:0]        ta;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SHIFT = 2'd1,
        SQ_GAP   = 2'd2
    } sq_state_e;

    // Index counts down; values at or above CMD_W are preamble positions.
    function automatic logic is_preamble(input logic [IDX_W-1:0] idx);
        return int'(idx) >= CMD_W;
    endfunction

    function automatic logic drives_bit(input logic [1:0] op,
                                        input logic [IDX_W-1:0] idx);
        if (is_preamble(idx))
            return 1'b1;
        if (op != OP_READ)
            return 1'b1;
        return int'(idx) > REL_MSB;
    endfunction

    function automatic logic frame_bit(input mdio_cmd_t cmd,
                                       input logic [IDX_W-1:0] idx);
        logic [CMD_W-1:0] raw;
        raw = cmd;
        if (is_preamble(idx))
            return 1'b1;
        return raw[idx[$clog2(CMD_W)-1:0]];
    endfunction

    function automatic logic captures_bit(input logic [1:0] op,
                                          input logic [IDX_W-1:0] idx);
        return (op == OP_READ) && (int'(idx) < DATA_W);
    endfunction

endpackage

// File: rtl/mdio_ctrl_reg.sv
module mdio_ctrl_reg #(
    parameter int          DIV_W     = 7,
    parameter logic [DIV_W-1:0] DIV_RESET = 7'h1a,
    parameter logic        PRE_RESET = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_div,
    input  logic             wr_pre,
    output logic [DIV_W-1:0] div,
    output logic             pre_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div    <= DIV_RESET;
            pre_en <= PRE_RESET;
        end else if (wr_en) begin
            div    <= wr_div;
            pre_en <= wr_pre;
        end
    end

endmodule

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);

    logic [DIV_W-1:0] cnt;
    logic             half_done;

    assign half_done = run && (cnt >= div);
    assign rise_p    = half_done && !mdc;
    assign fall_p    = half_done && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (half_done) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cmd,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             pre_en,
    input  logic             rise_p,
    input  logic             fall_p,
    input  logic             mdio_i,
    output logic             busy,
    output logic [CMD_W-1:0] cmd_word,
    output logic             mdio_o,
    output logic             mdio_oe
);

    localparam logic [IDX_W-1:0] IDX_PRE   = IDX_W'(PRE_LEN + CMD_W - 1);
    localparam logic [IDX_W-1:0] IDX_NOPRE = IDX_W'(CMD_W - 1);

    sq_state_e        state;
    mdio_cmd_t        cmd_q;
    logic [IDX_W-1:0] bidx;
    logic             shifting;

    assign shifting = (state == SQ_SHIFT);
    assign busy     = (state != SQ_IDLE);
    assign cmd_word = cmd_q;
    assign mdio_oe  = shifting && drives_bit(cmd_q.op, bidx);
    assign mdio_o   = mdio_oe && frame_bit(cmd_q, bidx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cmd_q <= '0;
            bidx  <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (wr_cmd) begin
                        cmd_q <= mdio_cmd_t'(wr_data);
                        bidx  <= pre_en ? IDX_PRE : IDX_NOPRE;
                        state <= SQ_SHIFT;
                    end
                end
                SQ_SHIFT: begin
                    if (rise_p && captures_bit(cmd_q.op, bidx))
                        cmd_q.data[bidx[$clog2(DATA_W)-1:0]] <= mdio_i;
                    if (fall_p) begin
                        if (bidx == '0)
                            state <= SQ_GAP;
                        else
                            bidx <= bidx - 1'b1;
                    end
                end
                SQ_GAP: begin
                    if (fall_p)
                        state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int               DIV_W     = 7,
    parameter logic [DIV_W-1:0] DIV_RESET = 7'h1a,
    parameter logic             PRE_RESET = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic [DIV_W-1:0] div;
    logic             pre_en;
    logic             busy;
    logic             rise_p;
    logic             fall_p;
    logic [CMD_W-1:0] cmd_q;
    logic [31:0]      ctrl_word;

    mdio_ctrl_reg #(
        .DIV_W    (DIV_W),
        .DIV_RESET(DIV_RESET),
        .PRE_RESET(PRE_RESET)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr && !reg_sel),
        .wr_div(reg_wdata[DIV_W-1:0]),
        .wr_pre(reg_wdata[PRE_BIT]),
        .div   (div),
        .pre_en(pre_en)
    );

    mdio_clk_div #(
        .DIV_W(DIV_W)
    ) u_clk (
        .clk   (clk),
        .rst   (rst),
        .run   (busy),
        .div   (div),
        .mdc   (mdc),
        .rise_p(rise_p),
        .fall_p(fall_p)
    );

    mdio_frame_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_cmd  (reg_wr && reg_sel),
        .wr_data (reg_wdata),
        .pre_en  (pre_en),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .cmd_word(cmd_q),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    always_comb begin
        ctrl_word              = '0;
        ctrl_word[DIV_W-1:0]   = div;
        ctrl_word[PRE_BIT]     = pre_en;
        ctrl_word[BUSY_BIT]    = busy;
    end

    assign reg_rdata = reg_sel ? cmd_q : ctrl_word;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic        busy,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [15:0] cmd_hi
);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    p_mdc_only_busy_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> busy);

    p_launch_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel && !busy) |=> busy);

    p_change_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

    p_cmd_held_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_hi));

    p_release_before_done_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!$past(mdio_oe) && !mdc));

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .reg_wr (reg_wr),
    .reg_sel(reg_sel),
    .busy   (busy),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe),
    .cmd_hi (cmd_q[31:16])
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    mdio_master u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Scoreboard item: expected pin state at one MDC rising edge.
    typedef struct packed {
        logic [1:0] kind;   // 0 preamble, 1 frame bit, 2 closing gap
        logic       oe;
        logic       val;
    } item_t;
    item_t expq[$];

    int cur_p = 0;
    int last_rise = 0;

    // PHY model: presents its read value after each falling MDC edge.
    logic [15:0] phy_val = '0;
    int phy_n = 32;
    int pos = 0;
    always @(negedge mdc) pos++;

    function automatic logic phy_bit(input int n, input int p, input logic [15:0] v);
        int idx;
        idx = n - 1 - p;
        if (idx >= 0 && idx <= 15) return v[idx];
        return 1'b1;
    endfunction
    assign mdio_i = phy_bit(phy_n, pos, phy_val);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string kind_req(input logic [1:0] k);
        case (k)
            2'd0: return "R5 preamble bit";
            2'd1: return "R6/R7 frame bit";
            default: return "R10 closing gap";
        endcase
    endfunction

    // Monitor: pop one expected item per rising MDC edge.
    initial begin
        forever begin
            @(posedge mdc);
            #1;
            if (last_rise != 0)
                chk((cyc - last_rise) == cur_p, "R3 MDC period", cyc - last_rise, cur_p);
            last_rise = cyc;
            if (expq.size() == 0) begin
                chk(1'b0, "R4 unexpected MDC edge", {mdio_oe, mdio_o}, 0);
            end else begin
                item_t it;
                it = expq.pop_front();
                if (it.oe)
                    chk(mdio_oe && (mdio_o == it.val), kind_req(it.kind),
                        {mdio_oe, mdio_o}, {it.oe, it.val});
                else
                    chk(!mdio_oe, kind_req(it.kind), {mdio_oe, mdio_o}, {it.oe, it.val});
            end
        end
    end

    task automatic reg_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic reg_read(input logic sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1;
        d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] phy,
                                           input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, phy, ra, 2'b10, d};
    endfunction

    // Driver: push the expected frame, launch it, time busy, check the result.
    task automatic run_frame(input logic [31:0] cmd, input bit pre, input int div,
                             input int inj_at, input logic [15:0] rd_val);
        int cnt;
        int nbits;
        logic [31:0] got, exp;
        bit is_rd;
        item_t it;
        is_rd = (cmd[29:28] == 2'b10);
        cur_p = 2 * (div + 1);
        nbits = pre ? 64 : 32;
        if (pre)
            for (int i = 0; i < 32; i++) begin
                it.kind = 2'd0; it.oe = 1'b1; it.val = 1'b1; expq.push_back(it);
            end
        for (int i = 31; i >= 0; i--) begin
            it.kind = 2'd1;
            it.oe   = !(is_rd && i <= 17);
            it.val  = it.oe ? cmd[i] : 1'b0;
            expq.push_back(it);
        end
        it.kind = 2'd2; it.oe = 1'b0; it.val = 1'b0; expq.push_back(it);
        phy_val = rd_val; phy_n = nbits; pos = 0; last_rise = 0;
        reg_write(1'b1, cmd);
        cnt = 0;
        #1;
        while (reg_rdata[8]) begin
            cnt++;
            @(negedge clk);
            if (cnt == inj_at) begin
                reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = ~cmd;   // R9 ignored write
                @(negedge clk);
                cnt++;
                reg_wr = 1'b0; reg_sel = 1'b0;
            end
            #1;
        end
        chk(cnt == (nbits + 1) * cur_p, "R4/R5 busy duration", cnt, (nbits + 1) * cur_p);
        chk(expq.size() == 0, "R4 all frame bits seen", expq.size(), 0);
        chk(!mdc && !mdio_oe, "R10 idle after frame", {mdc, mdio_oe}, 0);
        reg_read(1'b1, got);
        exp = is_rd ? {cmd[31:16], rd_val} : cmd;
        chk(got == exp, is_rd ? "R8 read capture" : "R9 data register kept", got, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        reg_read(1'b0, r);
        chk(r == 32'h0000_009a, "R1 control reset", r, 32'h9a);
        reg_read(1'b1, r);
        chk(r == 32'h0, "R1 data reset", r, 0);
        chk(!mdc && !mdio_oe, "R1 pins idle", {mdc, mdio_oe}, 0);
        repeat (5) @(negedge clk);
        chk(!mdc, "R3 MDC low while idle", mdc, 0);

        // R2 control write; bit 8 not writable
        reg_write(1'b0, 32'h0000_0181);
        reg_read(1'b0, r);
        chk(r == 32'h0000_0081, "R2 control readback", r, 32'h81);

        // Write frame, preamble on, divider 1
        run_frame(mk_cmd(2'b01, 5'd5, 5'd3, 16'ha55a), 1'b1, 1, -1, 16'h0);
        // Read frame, preamble on
        run_frame(mk_cmd(2'b10, 5'd1, 5'd2, 16'h0), 1'b1, 1, -1, 16'hc3e1);

        // Preamble off, divider 3
        reg_write(1'b0, 32'h0000_0003);
        reg_read(1'b0, r);
        chk(r == 32'h0000_0003, "R2 control readback no preamble", r, 32'h3);
        run_frame(mk_cmd(2'b10, 5'h1f, 5'h1f, 16'h0), 1'b0, 3, -1, 16'h8001);
        // Write while busy ignored, on a write and on a read frame
        run_frame(mk_cmd(2'b01, 5'h0a, 5'h15, 16'hffff), 1'b0, 3, 40, 16'h0);
        run_frame(mk_cmd(2'b10, 5'h12, 5'h07, 16'h0), 1'b0, 3, 100, 16'h5a3c);

        repeat (10) @(negedge clk);
        chk(!mdc && !mdio_oe, "R3 MDC low at end", {mdc, mdio_oe}, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule